// File: doc/BRIEF.md
# Banked Short-Address Register Decoder

This block sits beside an instruction decoder. It turns the addresses an instruction uses into full 24-bit register addresses. Long 16-bit and indirect addresses are zero-extended and passed through. Short 8-bit register offsets and direct bit addresses carry no base of their own, so the block supplies one. That base comes from one of two 512-byte register areas: the standard area at 00FE00h and the extended area at 00F000h.

A small counter decides which area short addresses use. An "extend" command, retired together with a count from 1 to 4, points short addressing at the extended area for that many following retired instructions. After those instructions, short addressing falls back to the standard area. General-purpose registers reached through short offsets are never redirected, and neither are long or indirect addresses.

The block also classifies each target. It reports the area, the general-purpose register index, and whether the word may take bit operations. It produces the byte-lane write enables, plus a strobe that tells the register file to clear the other byte of the word when a single byte of a register is written. All outputs except the window state follow the inputs combinationally in the same cycle.

Top module: `sfr_bank_decoder`

## Requirements
- R1: Area codes on `area_o` are 0 = other, 1 = standard, 2 = extended and 3 = general-purpose register. A long or indirect address in 00FE00h..00FFFFh reports 1, one in 00F000h..00F1FFh reports 2, and any other reports 0.
- R2: For a short register access (mode 2) with offset below F0h, the address is area base + 2 × offset. A byte write in this mode enables only the low lane (`byte_en_o` = 01).
- R3: `bit_ok_o` is 1 for an area word whose offset within its area is 100h or more, and for any general-purpose register target. Otherwise it is 0.
- R4: A retired extend command (`retire_i` and `ext_cmd_i` both high) with a count N of 1..4 makes short register and bit accesses use the extended base for the next N retired instructions. After that they use the standard base. `ext_active_o` is high during this window. `ext_cmd_i` without `retire_i` has no effect.
- R5: Long (mode 0) and indirect (mode 1) addresses leave as {8'h00, addr_i} and get the same area code whether or not the window is active.
- R6: Mode 3 selects general-purpose register `addr_i[3:0]`. Short register offsets F0h..FFh and bit word offsets F0h..FFh also select a register, with the index in the low nibble of the offset. All of these report area 3 with `phys_addr_o` = 0, whatever the window state.
- R7: With `wr_i` low, `byte_en_o` = 00 and `clr_other_o` = 0. A word write gives 11. A long or indirect byte write enables lane `addr_i[0]` (01 for even, 10 for odd). `clr_other_o` is 1 only for a single-lane write into area 1 or 2. A bit-mode write always enables both lanes.
- R8: A bit access (mode 4) takes its word offset from `addr_i[7:0]` and its bit position from `addr_i[11:8]`, and `bit_mask_o` = 1 << position. Offsets 80h..EFh give base + 2 × offset. Offsets below 80h give area 0, address 0 and `bit_ok_o` = 0. `bit_mask_o` is 0 in every other mode.
- R9: An extend command retired while the window is open reloads the counter with the new count.
- R10: Reset clears the window, so that short addresses use the standard area.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_i | input | 1 | One instruction retires this cycle |
| ext_cmd_i | input | 1 | The retiring instruction is an extend command |
| ext_cnt_i | input | 3 | Window length carried by the extend command (1..4) |
| mode_i | input | 3 | Address mode: 0 long, 1 indirect, 2 short register, 3 short GPR, 4 bit |
| addr_i | input | 16 | Long address, or short offset with bit position in [11:8] |
| wr_i | input | 1 | The access writes |
| byte_i | input | 1 | The write is byte-sized |
| phys_addr_o | output | 24 | Translated register address |
| area_o | output | 2 | Target area code |
| gpr_idx_o | output | 4 | General-purpose register index (0 when not a register) |
| byte_en_o | output | 2 | Lane write enables, bit 0 = low byte |
| clr_other_o | output | 1 | Clear the non-written byte of the word |
| bit_ok_o | output | 1 | Target word accepts bit operations |
| bit_mask_o | output | 16 | One-hot bit select for bit accesses |
| ext_active_o | output | 1 | Extend window is open |

## Verification
The properties assume that the decoder only retires an extend command whose count lies between 1 and the configured maximum, and one of them reports any violation of that assumption. They also assume that `mode_i` holds one of the five defined codes. The stimulus keeps to both: every extend command carries a legal count, and only defined modes are driven. The other inputs are driven freely, including `ext_cmd_i` without a retire strobe, which the window must ignore.

// File: rtl/sfrdec_pkg.sv
package sfrdec_pkg;

   typedef enum logic [2:0] {
      AM_LONG  = 3'd0,
      AM_INDIR = 3'd1,
      AM_SREG  = 3'd2,
      AM_SGPR  = 3'd3,
      AM_BIT   = 3'd4
   } amode_e;

   typedef enum logic [1:0] {
      AR_OTHER = 2'd0,
      AR_STD   = 2'd1,
      AR_EXT   = 2'd2,
      AR_GPR   = 2'd3
   } area_e;

   function automatic logic is_sfr_area(area_e a);
      return (a == AR_STD) || (a == AR_EXT);
   endfunction

endpackage

// File: rtl/sfrdec_window.sv
// Counted extend window: loaded by a retired extend command and
// decremented by every other retired instruction.
module sfrdec_window #(
   parameter int MAX_EXT = 4,
   localparam int CNT_W = $clog2(MAX_EXT + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             retire_i,
   input  logic             ext_cmd_i,
   input  logic [CNT_W-1:0] ext_cnt_i,
   output logic             active_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_EXT);

   logic [CNT_W-1:0] remain_q;
   logic [CNT_W-1:0] load_val;

   // Out-of-range counts are clamped so that the window can never outlive MAX_EXT.
   always_comb begin
      load_val = ext_cnt_i;
      if (ext_cnt_i > CNT_MAX) begin
         load_val = CNT_MAX;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain_q <= '0;
      end else if (retire_i) begin
         if (ext_cmd_i) begin
            remain_q <= load_val;
         end else if (remain_q != '0) begin
            remain_q <= remain_q - 1'b1;
         end
      end
   end

   assign active_o = (remain_q != '0);

endmodule

// File: rtl/sfrdec_map.sv
// Address translation: long/indirect pass-through, short register and
// bit addresses relative to the selected area base, GPR window.
module sfrdec_map
   import sfrdec_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int LONG_W     = 16,
   parameter int SHORT_W    = 8,
   parameter int WORD_W     = 16,
   parameter int GPR_N      = 16,
   parameter int AREA_BYTES = 512,
   parameter int STD_BASE   = 'hFE00,
   parameter int EXT_BASE   = 'hF000,
   parameter bit GPR_SHADOW = 1'b1,
   localparam int GIDX_W    = $clog2(GPR_N),
   localparam int POS_W     = $clog2(WORD_W)
) (
   input  amode_e              mode_i,
   input  logic [LONG_W-1:0]   addr_i,
   input  logic                use_ext_i,
   output logic [ADDR_W-1:0]   phys_o,
   output area_e               area_o,
   output logic [GIDX_W-1:0]   gpr_idx_o,
   output logic                bit_ok_o,
   output logic [WORD_W-1:0]   mask_o
);

   localparam logic [ADDR_W-1:0]  STD_B     = ADDR_W'(STD_BASE);
   localparam logic [ADDR_W-1:0]  EXT_B     = ADDR_W'(EXT_BASE);
   localparam logic [ADDR_W-1:0]  STD_END   = ADDR_W'(STD_BASE + AREA_BYTES);
   localparam logic [ADDR_W-1:0]  EXT_END   = ADDR_W'(EXT_BASE + AREA_BYTES);
   localparam logic [ADDR_W-1:0]  HALF_OFF  = ADDR_W'(AREA_BYTES / 2);
   localparam logic [SHORT_W-1:0] GPR_FIRST = SHORT_W'((1 << SHORT_W) - GPR_N);

   logic [SHORT_W-1:0] off;
   logic [POS_W-1:0]   pos;
   logic [ADDR_W-1:0]  long_addr;
   logic [ADDR_W-1:0]  base;
   logic [ADDR_W-1:0]  short_phys;
   area_e              short_area;
   logic               off_in_gpr;
   logic               sreg_gpr;
   logic               in_std;
   logic               in_ext;

   assign off        = addr_i[SHORT_W-1:0];
   assign pos        = addr_i[SHORT_W +: POS_W];
   assign long_addr  = ADDR_W'(addr_i);
   assign base       = use_ext_i ? EXT_B : STD_B;
   assign short_area = use_ext_i ? AR_EXT : AR_STD;
   assign short_phys = base + ADDR_W'({off, 1'b0});
   assign off_in_gpr = (off >= GPR_FIRST);
   assign in_std     = (long_addr >= STD_B) && (long_addr < STD_END);
   assign in_ext     = (long_addr >= EXT_B) && (long_addr < EXT_END);

   // Variant: the GPR window may or may not shadow the top short offsets.
   generate
      if (GPR_SHADOW) begin : g_shadow
         assign sreg_gpr = off_in_gpr;
      end else begin : g_no_shadow
         assign sreg_gpr = 1'b0;
      end
   endgenerate

   always_comb begin
      phys_o    = '0;
      area_o    = AR_OTHER;
      gpr_idx_o = '0;
      bit_ok_o  = 1'b0;
      unique case (mode_i)
         AM_SREG: begin
            if (sreg_gpr) begin
               area_o    = AR_GPR;
               gpr_idx_o = off[GIDX_W-1:0];
               bit_ok_o  = 1'b1;
            end else begin
               area_o    = short_area;
               phys_o    = short_phys;
               bit_ok_o  = off[SHORT_W-1];
            end
         end
         AM_SGPR: begin
            area_o    = AR_GPR;
            gpr_idx_o = addr_i[GIDX_W-1:0];
            bit_ok_o  = 1'b1;
         end
         AM_BIT: begin
            if (off_in_gpr) begin
               area_o    = AR_GPR;
               gpr_idx_o = off[GIDX_W-1:0];
               bit_ok_o  = 1'b1;
            end else if (off[SHORT_W-1]) begin
               area_o    = short_area;
               phys_o    = short_phys;
               bit_ok_o  = 1'b1;
            end
         end
         default: begin
            phys_o = long_addr;
            if (in_std) begin
               area_o   = AR_STD;
               bit_ok_o = (long_addr - STD_B) >= HALF_OFF;
            end else if (in_ext) begin
               area_o   = AR_EXT;
               bit_ok_o = (long_addr - EXT_B) >= HALF_OFF;
            end
         end
      endcase
   end

   // One decoder cell per bit of the word.
   generate
      for (genvar b = 0; b < WORD_W; b++) begin : g_mask
         assign mask_o[b] = (mode_i == AM_BIT) && (pos == POS_W'(b));
      end
   endgenerate

endmodule

// File: rtl/sfrdec_lanes.sv
// Byte-lane enables and the clear-complementary-byte strobe.
module sfrdec_lanes
   import sfrdec_pkg::*;
(
   input  amode_e       mode_i,
   input  logic         addr_lsb_i,
   input  area_e        area_i,
   input  logic         wr_i,
   input  logic         byte_i,
   output logic [1:0]   be_o,
   output logic         clr_o
);

   always_comb begin
      be_o = 2'b00;
      if (wr_i) begin
         if (!byte_i || mode_i == AM_BIT) begin
            be_o = 2'b11;
         end else if (mode_i == AM_SREG || mode_i == AM_SGPR) begin
            be_o = 2'b01;
         end else begin
            be_o = addr_lsb_i ? 2'b10 : 2'b01;
         end
      end
   end

   assign clr_o = (be_o == 2'b01 || be_o == 2'b10) && is_sfr_area(area_i);

endmodule

// File: rtl/sfr_bank_decoder.sv
module sfr_bank_decoder
   import sfrdec_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int LONG_W     = 16,
   parameter int SHORT_W    = 8,
   parameter int WORD_W     = 16,
   parameter int GPR_N      = 16,
   parameter int AREA_BYTES = 512,
   parameter int STD_BASE   = 'hFE00,
   parameter int EXT_BASE   = 'hF000,
   parameter int MAX_EXT    = 4,
   parameter bit GPR_SHADOW = 1'b1,
   localparam int CNT_W     = $clog2(MAX_EXT + 1),
   localparam int GIDX_W    = $clog2(GPR_N)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              retire_i,
   input  logic              ext_cmd_i,
   input  logic [CNT_W-1:0]  ext_cnt_i,
   input  logic [2:0]        mode_i,
   input  logic [LONG_W-1:0] addr_i,
   input  logic              wr_i,
   input  logic              byte_i,
   output logic [ADDR_W-1:0] phys_addr_o,
   output logic [1:0]        area_o,
   output logic [GIDX_W-1:0] gpr_idx_o,
   output logic [1:0]        byte_en_o,
   output logic              clr_other_o,
   output logic              bit_ok_o,
   output logic [WORD_W-1:0] bit_mask_o,
   output logic              ext_active_o
);

   // Elaboration-time parameter checks.
   generate
      if (AREA_BYTES != (2 << SHORT_W)) begin : g_bad_area
         $error("AREA_BYTES must equal two bytes per short offset");
      end
      if (WORD_W != 16) begin : g_bad_word
         $error("lane logic assumes a 16-bit word");
      end
      if ((GPR_N & (GPR_N - 1)) != 0 || GPR_N > (1 << (SHORT_W - 1))) begin : g_bad_gpr
         $error("GPR_N must be a power of two inside the upper short half");
      end
      if (MAX_EXT < 1) begin : g_bad_ext
         $error("MAX_EXT must be at least 1");
      end
      if ((STD_BASE % AREA_BYTES) != 0 || (EXT_BASE % AREA_BYTES) != 0) begin : g_bad_base
         $error("area bases must be aligned to the area size");
      end
      if (LONG_W + SHORT_W > ADDR_W + SHORT_W || LONG_W < SHORT_W + $clog2(WORD_W)) begin : g_bad_long
         $error("address widths are inconsistent");
      end
   endgenerate

   amode_e mode;
   area_e  area;
   logic   win_open;

   assign mode = amode_e'(mode_i);

   sfrdec_window #(
      .MAX_EXT (MAX_EXT)
   ) u_window (
      .clk       (clk),
      .rst_n     (rst_n),
      .retire_i  (retire_i),
      .ext_cmd_i (ext_cmd_i),
      .ext_cnt_i (ext_cnt_i),
      .active_o  (win_open)
   );

   sfrdec_map #(
      .ADDR_W     (ADDR_W),
      .LONG_W     (LONG_W),
      .SHORT_W    (SHORT_W),
      .WORD_W     (WORD_W),
      .GPR_N      (GPR_N),
      .AREA_BYTES (AREA_BYTES),
      .STD_BASE   (STD_BASE),
      .EXT_BASE   (EXT_BASE),
      .GPR_SHADOW (GPR_SHADOW)
   ) u_map (
      .mode_i    (mode),
      .addr_i    (addr_i),
      .use_ext_i (win_open),
      .phys_o    (phys_addr_o),
      .area_o    (area),
      .gpr_idx_o (gpr_idx_o),
      .bit_ok_o  (bit_ok_o),
      .mask_o    (bit_mask_o)
   );

   sfrdec_lanes u_lanes (
      .mode_i     (mode),
      .addr_lsb_i (addr_i[0]),
      .area_i     (area),
      .wr_i       (wr_i),
      .byte_i     (byte_i),
      .be_o       (byte_en_o),
      .clr_o      (clr_other_o)
   );

   assign area_o       = area;
   assign ext_active_o = win_open;

endmodule

// File: rtl/sfrdec_checker.sv
module sfrdec_checker
   import sfrdec_pkg::*;
#(
   parameter int ADDR_W  = 24,
   parameter int LONG_W  = 16,
   parameter int WORD_W  = 16,
   parameter int GIDX_W  = 4,
   parameter int CNT_W   = 3,
   parameter int MAX_EXT = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              retire_i,
   input logic              ext_cmd_i,
   input logic [CNT_W-1:0]  ext_cnt_i,
   input logic [2:0]        mode_i,
   input logic [LONG_W-1:0] addr_i,
   input logic              wr_i,
   input logic              byte_i,
   input logic [ADDR_W-1:0] phys_addr_o,
   input logic [1:0]        area_o,
   input logic [GIDX_W-1:0] gpr_idx_o,
   input logic [1:0]        byte_en_o,
   input logic              clr_other_o,
   input logic [WORD_W-1:0] bit_mask_o,
   input logic              ext_active_o
);

   logic cmd_now;
   logic is_long;
   assign cmd_now = retire_i && ext_cmd_i;
   assign is_long = (mode_i == AM_LONG) || (mode_i == AM_INDIR);

   AST_CMD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_now |-> (ext_cnt_i >= 1 && ext_cnt_i <= CNT_W'(MAX_EXT))); // R4

   AST_WIN_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_now |=> ext_active_o); // R4

   AST_WIN_STAYS_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
      (!ext_active_o && !cmd_now) |=> !ext_active_o); // R4

   AST_EXT_NEEDS_WIN: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_long && area_o == AR_EXT) |-> ext_active_o); // R4

   AST_LONG_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      is_long |-> (phys_addr_o == ADDR_W'(addr_i) && area_o != AR_GPR)); // R5

   AST_GPR_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == AM_SGPR) |-> (area_o == AR_GPR && gpr_idx_o == addr_i[GIDX_W-1:0])); // R6

   AST_SHORT_LOW_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == AM_SREG && wr_i && byte_i) |-> (byte_en_o == 2'b01)); // R2

   AST_CLR_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      clr_other_o |-> ($countones(byte_en_o) == 1 && wr_i && byte_i)); // R7

   AST_IDLE_NO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_i |-> (byte_en_o == 2'b00 && !clr_other_o)); // R7

   AST_MASK_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_i == AM_BIT) |-> ($countones(bit_mask_o) == 1)); // R8

endmodule

bind sfr_bank_decoder sfrdec_checker #(
   .ADDR_W  (ADDR_W),
   .LONG_W  (LONG_W),
   .WORD_W  (WORD_W),
   .GIDX_W  (GIDX_W),
   .CNT_W   (CNT_W),
   .MAX_EXT (MAX_EXT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .retire_i     (retire_i),
   .ext_cmd_i    (ext_cmd_i),
   .ext_cnt_i    (ext_cnt_i),
   .mode_i       (mode_i),
   .addr_i       (addr_i),
   .wr_i         (wr_i),
   .byte_i       (byte_i),
   .phys_addr_o  (phys_addr_o),
   .area_o       (area_o),
   .gpr_idx_o    (gpr_idx_o),
   .byte_en_o    (byte_en_o),
   .clr_other_o  (clr_other_o),
   .bit_mask_o   (bit_mask_o),
   .ext_active_o (ext_active_o)
);

// File: tb/sfr_bank_decoder_test.sv
module sfr_bank_decoder_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        retire_i = 1'b0;
   logic        ext_cmd_i = 1'b0;
   logic [2:0]  ext_cnt_i = 3'd0;
   logic [2:0]  mode_i = 3'd0;
   logic [15:0] addr_i = 16'h0;
   logic        wr_i = 1'b0;
   logic        byte_i = 1'b0;
   logic [23:0] phys_addr_o;
   logic [1:0]  area_o;
   logic [3:0]  gpr_idx_o;
   logic [1:0]  byte_en_o;
   logic        clr_other_o;
   logic        bit_ok_o;
   logic [15:0] bit_mask_o;
   logic        ext_active_o;

   int total = 0;
   int bad = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   sfr_bank_decoder uut (
      .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .ext_cmd_i(ext_cmd_i),
      .ext_cnt_i(ext_cnt_i), .mode_i(mode_i), .addr_i(addr_i), .wr_i(wr_i),
      .byte_i(byte_i), .phys_addr_o(phys_addr_o), .area_o(area_o),
      .gpr_idx_o(gpr_idx_o), .byte_en_o(byte_en_o), .clr_other_o(clr_other_o),
      .bit_ok_o(bit_ok_o), .bit_mask_o(bit_mask_o), .ext_active_o(ext_active_o)
   );

   // {mode, addr, wr, byte, phys, area, be, clr, bit_ok, mask}; window closed
   localparam int NV = 16;
   localparam logic [66:0] VEC [NV] = '{
      {3'd0, 16'hFE10, 1'b1, 1'b0, 24'h00FE10, 2'd1, 2'b11, 1'b0, 1'b0, 16'h0000},
      {3'd0, 16'hFF21, 1'b1, 1'b1, 24'h00FF21, 2'd1, 2'b10, 1'b1, 1'b1, 16'h0000},
      {3'd0, 16'hF1F0, 1'b0, 1'b0, 24'h00F1F0, 2'd2, 2'b00, 1'b0, 1'b1, 16'h0000},
      {3'd0, 16'h1234, 1'b1, 1'b1, 24'h001234, 2'd0, 2'b01, 1'b0, 1'b0, 16'h0000},
      {3'd1, 16'hF002, 1'b1, 1'b1, 24'h00F002, 2'd2, 2'b01, 1'b1, 1'b0, 16'h0000},
      {3'd2, 16'h0040, 1'b1, 1'b0, 24'h00FE80, 2'd1, 2'b11, 1'b0, 1'b0, 16'h0000},
      {3'd2, 16'h0090, 1'b1, 1'b1, 24'h00FF20, 2'd1, 2'b01, 1'b1, 1'b1, 16'h0000},
      {3'd2, 16'h00F5, 1'b1, 1'b1, 24'h000000, 2'd3, 2'b01, 1'b0, 1'b1, 16'h0000},
      {3'd3, 16'h0007, 1'b1, 1'b0, 24'h000000, 2'd3, 2'b11, 1'b0, 1'b1, 16'h0000},
      {3'd4, 16'h0C92, 1'b0, 1'b0, 24'h00FF24, 2'd1, 2'b00, 1'b0, 1'b1, 16'h1000},
      {3'd4, 16'h03F2, 1'b1, 1'b0, 24'h000000, 2'd3, 2'b11, 1'b0, 1'b1, 16'h0008},
      {3'd4, 16'h0512, 1'b0, 1'b0, 24'h000000, 2'd0, 2'b00, 1'b0, 1'b0, 16'h0020},
      {3'd0, 16'hF200, 1'b1, 1'b1, 24'h00F200, 2'd0, 2'b01, 1'b0, 1'b0, 16'h0000},
      {3'd0, 16'hFDFF, 1'b0, 1'b0, 24'h00FDFF, 2'd0, 2'b00, 1'b0, 1'b0, 16'h0000},
      {3'd1, 16'hFFFF, 1'b1, 1'b1, 24'h00FFFF, 2'd1, 2'b10, 1'b1, 1'b1, 16'h0000},
      {3'd4, 16'h0C92, 1'b1, 1'b1, 24'h00FF24, 2'd1, 2'b11, 1'b0, 1'b1, 16'h1000}
   };

   task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic string mode_req(logic [2:0] m);
      case (m)
         3'd2:    return "R2";
         3'd3:    return "R6";
         3'd4:    return "R8";
         default: return "R1";
      endcase
   endfunction

   task automatic drive(logic [2:0] m, logic [15:0] a, logic w, logic b);
      mode_i = m; addr_i = a; wr_i = w; byte_i = b;
      #1;
   endtask

   task automatic extend(logic [2:0] n);
      @(negedge clk);
      retire_i = 1'b1; ext_cmd_i = 1'b1; ext_cnt_i = n;
      @(negedge clk);
      retire_i = 1'b0; ext_cmd_i = 1'b0; ext_cnt_i = 3'd0;
   endtask

   task automatic retire_one();
      @(negedge clk);
      retire_i = 1'b1;
      @(negedge clk);
      retire_i = 1'b0;
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      // R10: window closed in reset
      drive(3'd2, 16'h0040, 1'b0, 1'b0);
      check("R10", "active in reset", 32'(ext_active_o), 32'd0);
      check("R10", "short addr in reset", 32'(phys_addr_o), 32'h00FE80);
      rst_n = 1'b1;
      @(negedge clk);

      // table walk, window closed
      for (int i = 0; i < NV; i++) begin
         logic [66:0] v;
         v = VEC[i];
         @(negedge clk);
         drive(v[66:64], v[63:48], v[47], v[46]);
         check(mode_req(v[66:64]), "phys", 32'(phys_addr_o), 32'(v[45:22]));
         check(mode_req(v[66:64]), "area", 32'(area_o), 32'(v[21:20]));
         check("R7", "byte_en", 32'(byte_en_o), 32'(v[19:18]));
         check("R7", "clr_other", 32'(clr_other_o), 32'(v[17]));
         check("R3", "bit_ok", 32'(bit_ok_o), 32'(v[16]));
         check("R8", "mask", 32'(bit_mask_o), 32'(v[15:0]));
      end

      // R6: register indices
      @(negedge clk);
      drive(3'd3, 16'h000B, 1'b0, 1'b0);
      check("R6", "gpr idx mode3", 32'(gpr_idx_o), 32'hB);
      drive(3'd2, 16'h00F5, 1'b0, 1'b0);
      check("R6", "gpr idx short", 32'(gpr_idx_o), 32'h5);

      // R4: command without retire is ignored
      @(negedge clk);
      ext_cmd_i = 1'b1; ext_cnt_i = 3'd2;
      @(negedge clk);
      ext_cmd_i = 1'b0; ext_cnt_i = 3'd0;
      drive(3'd2, 16'h0040, 1'b0, 1'b0);
      check("R4", "cmd w/o retire", 32'(phys_addr_o), 32'h00FE80);

      // R4/R5/R6: window of three instructions
      extend(3'd3);
      for (int k = 0; k < 4; k++) begin
         drive(3'd2, 16'h0040, 1'b0, 1'b0);
         check("R4", "win short phys", 32'(phys_addr_o), (k < 3) ? 32'h00F080 : 32'h00FE80);
         check("R4", "win short area", 32'(area_o), (k < 3) ? 32'd2 : 32'd1);
         check("R4", "win active", 32'(ext_active_o), (k < 3) ? 32'd1 : 32'd0);
         drive(3'd4, 16'h0C92, 1'b0, 1'b0);
         check("R4", "win bit phys", 32'(phys_addr_o), (k < 3) ? 32'h00F124 : 32'h00FF24);
         drive(3'd0, 16'hFE10, 1'b0, 1'b0);
         check("R5", "long phys", 32'(phys_addr_o), 32'h00FE10);
         check("R5", "long area", 32'(area_o), 32'd1);
         drive(3'd1, 16'hF002, 1'b0, 1'b0);
         check("R5", "indirect area", 32'(area_o), 32'd2);
         drive(3'd2, 16'h00F5, 1'b0, 1'b0);
         check("R6", "gpr in window", 32'(area_o), 32'd3);
         check("R6", "gpr idx window", 32'(gpr_idx_o), 32'h5);
         retire_one();
      end

      // R4: count 1 closes after a single instruction
      extend(3'd1);
      drive(3'd2, 16'h0010, 1'b0, 1'b0);
      check("R4", "n=1 first", 32'(phys_addr_o), 32'h00F020);
      retire_one();
      drive(3'd2, 16'h0010, 1'b0, 1'b0);
      check("R4", "n=1 after", 32'(phys_addr_o), 32'h00FE20);

      // R9: reload while open
      extend(3'd4);
      retire_one();
      extend(3'd1);
      drive(3'd2, 16'h0040, 1'b0, 1'b0);
      check("R9", "reload active", 32'(ext_active_o), 32'd1);
      retire_one();
      check("R9", "reload expiry", 32'(ext_active_o), 32'd0);
      check("R9", "reload std", 32'(phys_addr_o), 32'h00FE80);

      // R10: reset in the middle of a window
      extend(3'd4);
      @(negedge clk);
      rst_n = 1'b0;
      #2;
      check("R10", "reset closes", 32'(ext_active_o), 32'd0);
      check("R10", "reset std", 32'(phys_addr_o), 32'h00FE80);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule